// File: doc/BRIEF.md
# Snooped Write-Back Buffer

This block parks one dirty victim block that a cache miss has pushed out, so that the cache can fetch the missing block first and send the victim to memory later. While it holds a victim it asks for the bus. When it is granted, it places the victim's address and data on the bus together in a single write-back cycle. Memory takes that cycle before any new bus request.

While the victim waits, the buffer is still part of the coherent system. Every snooped read or read-for-ownership is compared against the parked block's tag, which is the address with the in-block offset bits dropped. On a hit the buffer raises the dirty snoop flag so that memory stays quiet. It then hands the block to the requester on its data output and drops its own write-back request. A processor miss that looks up the same block is served from the buffer in the same way, and the write-back is cancelled.

The controller has three states. FREE means no entry is held. PEND means the entry is held and the bus is requested. XFER means the bus is granted and the write-back is being driven. The transitions are:
- FREE→PEND on a victim load (LOAD).
- PEND→XFER on a grant (GRANT).
- PEND→FREE on a snoop hit (SNOOP_TAKE) or a processor lookup hit (MISS_TAKE).
- XFER→FREE after its single bus cycle (DONE).

Top module: `snoop_wb_buffer`

## Requirements
- R1: After reset, vic_ready is 1 and bus_req, bus_wb, snp_supply, snp_dirty and miss_hit are 0, with bus_addr, bus_data and out_data zero.
- R2: A vic_valid while vic_ready is 1 stores the victim. From the next cycle vic_ready is 0 and bus_req is 1.
- R3: While an entry is held, vic_ready stays 0 and vic_valid is ignored: the later write-back still carries the first victim's address and data.
- R4: bus_gnt while in PEND makes bus_wb 1 for exactly the next cycle. In that cycle bus_addr and bus_data carry the stored victim and bus_req is 0. Outside that cycle bus_addr and bus_data are zero.
- R5: The cycle after the write-back cycle, the entry is free again: vic_ready is 1 and bus_req is 0.
- R6: In PEND, snp_valid with snp_cmd READ (1) or READX (2) and a matching tag makes snp_supply and snp_dirty 1 for the next cycle, with out_data holding the stored data. In that same cycle bus_req drops to 0 and vic_ready rises to 1.
- R7: A snoop with a different tag, with snp_cmd UPGR (3) or NONE (0), or with snp_valid low causes no response and leaves the request pending.
- R8: A matching snoop in the same cycle as bus_gnt wins: the write-back is cancelled and bus_wb stays 0.
- R9: In PEND, miss_valid with a matching miss_addr tag makes miss_hit 1 for the next cycle, with out_data holding the stored data. The entry is freed and no write-back follows.
- R10: When a snoop hit and a processor lookup hit arrive in the same cycle, only the snoop is served: snp_supply is 1 and miss_hit is 0.
- R11: Snoops and processor lookups during the XFER cycle get no response.
- R12: Tag comparison ignores the low OFFW address bits (OFFW = 5 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vic_valid | input | 1 | Victim load strobe from the cache |
| vic_addr | input | AW | Victim block address |
| vic_data | input | DW | Victim block data |
| vic_ready | output | 1 | Buffer free, a victim can be loaded |
| bus_req | output | 1 | Bus request for the write-back |
| bus_gnt | input | 1 | Bus grant |
| bus_wb | output | 1 | Write-back cycle on the bus |
| bus_addr | output | AW | Write-back address |
| bus_data | output | DW | Write-back data |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snoop command: 0 NONE, 1 READ, 2 READX, 3 UPGR |
| snp_addr | input | AW | Snooped address |
| snp_supply | output | 1 | Buffer supplies data to the snooper |
| snp_dirty | output | 1 | Dirty snoop flag, inhibits memory |
| miss_valid | input | 1 | Processor miss lookup strobe |
| miss_addr | input | AW | Processor miss address |
| miss_hit | output | 1 | Lookup served from the buffer |
| out_data | output | DW | Block data for snoop or lookup hits |

## Verification
The hardest case to reach is a conflict that lands in a single cycle. It arises when a matching snoop arrives together with the grant, or together with a processor lookup of the same block, or when a snoop lands in the one XFER cycle. Directed sequences place these events on chosen cycles after a load. A random phase then draws tags from only four values with random offsets, so that matches and collisions with grants happen often.

// File: rtl/swb_pkg.sv
package swb_pkg;
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_PEND = 2'd1,
        ST_XFER = 2'd2
    } swb_state_e;

    typedef enum logic [1:0] {
        SC_NONE  = 2'd0,
        SC_READ  = 2'd1,
        SC_READX = 2'd2,
        SC_UPGR  = 2'd3
    } snp_cmd_e;

    localparam int NPROBE = 2;  // probe 0: snoop, probe 1: processor lookup
endpackage

// File: rtl/swb_store.sv
module swb_store
    import swb_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 64,
    parameter int OFFW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic [AW-1:0] snp_addr,
    input  logic [AW-1:0] miss_addr,
    output logic [AW-1:0] q_addr,
    output logic [DW-1:0] q_data,
    output logic          snp_match,
    output logic          miss_match
);
    localparam int TW = AW - OFFW;

    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     data_q;
    logic [AW-1:0]     probe [NPROBE];
    logic [NPROBE-1:0] hit_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (load) begin
            addr_q <= ld_addr;
            data_q <= ld_data;
        end
    end

    assign probe[0] = snp_addr;
    assign probe[1] = miss_addr;

    // one tag comparator per probe port
    generate
        for (genvar g = 0; g < NPROBE; g++) begin : g_cmp
            logic [TW-1:0] ptag;
            assign ptag       = probe[g][AW-1:OFFW];
            assign hit_vec[g] = (ptag == addr_q[AW-1:OFFW]);
        end
    endgenerate

    assign snp_match  = hit_vec[0];
    assign miss_match = hit_vec[1];
    assign q_addr     = addr_q;
    assign q_data     = data_q;
endmodule

// File: rtl/swb_fsm.sv
module swb_fsm
    import swb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vic_valid,
    input  logic bus_gnt,
    input  logic snp_hit_raw,
    input  logic miss_hit_raw,
    output logic load,
    output logic take_snp,
    output logic take_miss,
    output logic vic_ready,
    output logic bus_req,
    output logic bus_wb
);
    swb_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: if (vic_valid) state_d = ST_PEND;                // LOAD
            ST_PEND: begin
                if (snp_hit_raw || miss_hit_raw) state_d = ST_FREE;   // SNOOP_TAKE / MISS_TAKE
                else if (bus_gnt)                state_d = ST_XFER;   // GRANT
            end
            ST_XFER: state_d = ST_FREE;                               // DONE
            default: state_d = ST_FREE;
        endcase
    end

    always_comb begin
        load      = 1'b0;
        take_snp  = 1'b0;
        take_miss = 1'b0;
        vic_ready = 1'b0;
        bus_req   = 1'b0;
        bus_wb    = 1'b0;
        unique case (state_q)
            ST_FREE: begin
                vic_ready = 1'b1;
                load      = vic_valid;
            end
            ST_PEND: begin
                bus_req   = 1'b1;
                take_snp  = snp_hit_raw;
                take_miss = miss_hit_raw && !snp_hit_raw;
            end
            ST_XFER: bus_wb = 1'b1;
            default: ;
        endcase
    end

    p_load_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_valid && vic_ready) |=> bus_req);
    p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_hit_raw && !miss_hit_raw) |=> bus_req);
    p_wb_after_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wb) |-> $past(bus_req && bus_gnt));
    p_wb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wb |=> (!bus_wb && vic_ready));
    p_snoop_beats_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && snp_hit_raw) |=> !bus_wb);
endmodule

// File: rtl/swb_resp.sv
module swb_resp #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_snp,
    input  logic          take_miss,
    input  logic [DW-1:0] q_data,
    output logic          snp_supply,
    output logic          snp_dirty,
    output logic          miss_hit,
    output logic [DW-1:0] out_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snp_supply <= 1'b0;
            snp_dirty  <= 1'b0;
            miss_hit   <= 1'b0;
            out_data   <= '0;
        end else begin
            snp_supply <= take_snp;
            snp_dirty  <= take_snp;
            miss_hit   <= take_miss;
            out_data   <= (take_snp || take_miss) ? q_data : '0;
        end
    end

    p_one_taker_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(snp_supply && miss_hit));
endmodule

// File: rtl/snoop_wb_buffer.sv
module snoop_wb_buffer
    import swb_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 64,
    parameter int OFFW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vic_valid,
    input  logic [AW-1:0] vic_addr,
    input  logic [DW-1:0] vic_data,
    output logic          vic_ready,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_wb,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_data,
    input  logic          snp_valid,
    input  logic [1:0]    snp_cmd,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_supply,
    output logic          snp_dirty,
    input  logic          miss_valid,
    input  logic [AW-1:0] miss_addr,
    output logic          miss_hit,
    output logic [DW-1:0] out_data
);
    logic          load, take_snp, take_miss;
    logic          snp_match, miss_match, snp_hit_raw, miss_hit_raw, snp_is_read;
    logic [AW-1:0] q_addr;
    logic [DW-1:0] q_data;

    swb_store #(.AW(AW), .DW(DW), .OFFW(OFFW)) u_store (
        .clk(clk), .rst_n(rst_n), .load(load),
        .ld_addr(vic_addr), .ld_data(vic_data),
        .snp_addr(snp_addr), .miss_addr(miss_addr),
        .q_addr(q_addr), .q_data(q_data),
        .snp_match(snp_match), .miss_match(miss_match)
    );

    assign snp_is_read  = (snp_cmd == SC_READ) || (snp_cmd == SC_READX);
    assign snp_hit_raw  = snp_valid && snp_is_read && snp_match;
    assign miss_hit_raw = miss_valid && miss_match;

    swb_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .vic_valid(vic_valid), .bus_gnt(bus_gnt),
        .snp_hit_raw(snp_hit_raw), .miss_hit_raw(miss_hit_raw),
        .load(load), .take_snp(take_snp), .take_miss(take_miss),
        .vic_ready(vic_ready), .bus_req(bus_req), .bus_wb(bus_wb)
    );

    swb_resp #(.DW(DW)) u_resp (
        .clk(clk), .rst_n(rst_n), .take_snp(take_snp), .take_miss(take_miss),
        .q_data(q_data), .snp_supply(snp_supply), .snp_dirty(snp_dirty),
        .miss_hit(miss_hit), .out_data(out_data)
    );

    assign bus_addr = bus_wb ? q_addr : '0;
    assign bus_data = bus_wb ? q_data : '0;

    p_handoff_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (vic_ready && !bus_req));
    p_xfer_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wb |=> (!snp_supply && !miss_hit));
endmodule

// File: tb/sim_snoop_wb_buffer.sv
`timescale 1ns/1ps
module sim_snoop_wb_buffer;
    localparam int AW = 32, DW = 64, OFFW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          vic_valid = 0, bus_gnt = 0, snp_valid = 0, miss_valid = 0;
    logic [AW-1:0] vic_addr = 0, snp_addr = 0, miss_addr = 0;
    logic [DW-1:0] vic_data = 0;
    logic [1:0]    snp_cmd = 0;
    logic          vic_ready, bus_req, bus_wb, snp_supply, snp_dirty, miss_hit;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data, out_data;

    snoop_wb_buffer #(.AW(AW), .DW(DW), .OFFW(OFFW)) u0 (.*);

    int compared = 0, mismatched = 0;
    bit finished = 0;

    int            mst = 0;
    logic [AW-1:0] maddr = '0;
    logic [DW-1:0] mdata = '0;

    function automatic bit same_tag(logic [AW-1:0] a, logic [AW-1:0] b);
        return a[AW-1:OFFW] == b[AW-1:OFFW];
    endfunction

    task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic vv, input logic [AW-1:0] va, input logic [DW-1:0] vd,
                        input logic g, input logic sv, input logic [1:0] sc,
                        input logic [AW-1:0] sa, input logic mv, input logic [AW-1:0] ma);
        bit sh, mh;
        int nst;
        logic [DW-1:0] edat;
        @(negedge clk);
        vic_valid = vv; vic_addr = va; vic_data = vd; bus_gnt = g;
        snp_valid = sv; snp_cmd = sc; snp_addr = sa; miss_valid = mv; miss_addr = ma;
        sh   = (mst == 1) && sv && (sc == 2'd1 || sc == 2'd2) && same_tag(sa, maddr);
        mh   = (mst == 1) && mv && same_tag(ma, maddr) && !sh;
        edat = (sh || mh) ? mdata : '0;
        nst  = mst;
        case (mst)
            0: if (vv) begin nst = 1; maddr = va; mdata = vd; end
            1: if (sh || mh) nst = 0; else if (g) nst = 2;
            default: nst = 0;
        endcase
        mst = nst;
        @(posedge clk); #1;
        chk("R2", "vic_ready", DW'(vic_ready), DW'(mst == 0));
        chk("R3", "bus_req", DW'(bus_req), DW'(mst == 1));
        chk("R4", "bus_wb", DW'(bus_wb), DW'(mst == 2));
        chk("R4", "bus_addr", DW'(bus_addr), (mst == 2) ? DW'(maddr) : '0);
        chk("R4", "bus_data", bus_data, (mst == 2) ? mdata : '0);
        chk("R6", "snp_supply", DW'(snp_supply), DW'(sh));
        chk("R6", "snp_dirty", DW'(snp_dirty), DW'(sh));
        chk("R9", "miss_hit", DW'(miss_hit), DW'(mh));
        chk("R10", "out_data", out_data, edat);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    localparam logic [AW-1:0] A = 32'h0000_1040, B = 32'h0000_2080;
    localparam logic [DW-1:0] DA = 64'hA5A5_0001_DEAD_BEEF, DB = 64'h1234_5678_9ABC_DEF0;

    initial begin
        #(200000 * 4);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "vic_ready", DW'(vic_ready), 1);
        chk("R1", "bus_req", DW'(bus_req), 0);
        chk("R1", "bus_wb", DW'(bus_wb), 0);
        chk("R1", "snp_supply", DW'(snp_supply), 0);
        chk("R1", "snp_dirty", DW'(snp_dirty), 0);
        chk("R1", "miss_hit", DW'(miss_hit), 0);
        chk("R1", "bus_data", bus_data, 0);
        chk("R1", "out_data", out_data, 0);

        // R2 load, R3 second victim ignored, R7 non-matching snoops
        step(1, A, DA, 0, 0, 0, 0, 0, 0);
        step(1, B, DB, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 2'd1, B, 0, 0);
        step(0, 0, 0, 0, 1, 2'd3, A, 0, 0);
        step(0, 0, 0, 0, 0, 2'd1, A, 0, 0);
        step(0, 0, 0, 0, 1, 2'd0, A, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1, B);
        // R4 grant, R5 release, R11 probes in XFER ignored
        step(0, 0, 0, 1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 2'd2, A, 1, A);
        idle(1);
        // R6 snoop hit, R12 different offset in same block
        step(1, B, DB, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 2'd1, B | 32'h1F, 0, 0);
        idle(2);
        // R8 snoop beats grant
        step(1, A, DA, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 2'd2, A + 4, 0, 0);
        idle(2);
        // R9 processor lookup hit
        step(1, B, DB, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1, B + 8);
        idle(2);
        // R10 snoop and lookup together
        step(1, A, DA, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 2'd1, A, 1, A);
        idle(2);

        // random phase
        void'($urandom(32'd1357));
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] va, sa, ma;
            va = (AW'($urandom_range(3)) << OFFW) | AW'($urandom_range(31));
            sa = (AW'($urandom_range(3)) << OFFW) | AW'($urandom_range(31));
            ma = (AW'($urandom_range(3)) << OFFW) | AW'($urandom_range(31));
            step(1'($urandom_range(1)), va, {$urandom, $urandom},
                 1'($urandom_range(3) == 0), 1'($urandom_range(3) == 0),
                 2'($urandom_range(3)), sa, 1'($urandom_range(5) == 0), ma);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule